// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-side register file and address decoder of a 16550-style asynchronous serial channel. A host reaches it through a 3-bit address, an active-low chip select, read and write strobes and an 8-bit data bus. Each access is sampled on a rising clock edge. Writes update the control registers at that edge. Reads are captured into a data register and appear on the following cycle.

Bit 7 of the line control word is a bank bit. While it is set, addresses 0 and 1 reach the two divisor bytes instead of the data port and the interrupt enable register. Address 2 is split: it returns interrupt identification on read and loads FIFO control on write. The status addresses are read-only. Transmit data leaves as a one-cycle push pulse with its byte, and reading the receive buffer raises a one-cycle pop pulse. Both paths are right-justified to the configured word length. The serializer, deserializer, baud generator, FIFOs and interrupt priority logic sit outside the block. Their state arrives on inputs, and the divisor and control values are driven out.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, line control, modem control, interrupt enable, FIFO control, scratch and both divisor bytes are zero, and no push or pop pulse is active. A read of address 2 with int_id_i = 4'h1 returns 0x01.
- R2: While cs_ni is high, strobes have no effect: no register changes, no push or pop pulse occurs, and rdata_o holds.
- R3: With the bank bit (line control bit 7) clear, a write to address 0 gives tx_push_o high for exactly the next cycle, with tx_data_o equal to the written byte masked to the word length.
- R4: With the bank bit clear, a read of address 0 gives rx_pop_o high for exactly the next cycle and returns rx_data_i masked to the word length.
- R5: With the bank bit set, address 0 reads and writes the divisor low byte and address 1 the high byte. divisor_o is {high, low}, and no push or pop pulse occurs.
- R6: With the bank bit clear, address 1 reads and writes the interrupt enable register. Only its low 4 bits are stored, and the upper bits read as zero.
- R7: Address 2, whatever the bank bit, loads FIFO control on write. On read it returns {fifo_ctl[0], fifo_ctl[0], 2'b00, int_id_i}.
- R8: Addresses 3 (line control), 4 (modem control, low 5 bits stored) and 7 (scratch) read and write the same register whatever the bank bit.
- R9: Address 5 reads line_sts_i and address 6 reads modem_sts_i. Writes to either address change nothing.
- R10: Line control bits [1:0] set the word length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Bits above the word length read and push as zero.
- R11: rdata_o changes only on the clock edge after an accepted read and holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| tx_push_o | output | 1 | One-cycle push toward the transmit buffer |
| tx_data_o | output | 8 | Masked transmit byte |
| rx_pop_o | output | 1 | One-cycle pop toward the receive buffer |
| rx_data_i | input | 8 | Head of the receive buffer |
| int_id_i | input | 4 | Interrupt identification code |
| line_sts_i | input | 8 | Line status |
| modem_sts_i | input | 8 | Modem status |
| divisor_o | output | 16 | Baud divisor {high, low} |
| line_ctl_o | output | 8 | Line control value |
| modem_ctl_o | output | 5 | Modem control value |
| int_en_o | output | 4 | Interrupt enable value |
| fifo_ctl_o | output | 8 | FIFO control value |

## Verification
A wrong bank bit sends data writes into the divisor, or divisor writes into the transmit path. This shows on the next cycle as a missing or spurious tx_push_o and a divisor_o step. A corrupted control register shows on its output port one cycle after the bad write, and on rdata_o one cycle after the next read of that address. A wrong word-length decode shows as stray upper bits on tx_data_o or rdata_o at the first push or receive read. The bench compares every output against a behavioural model on every cycle, so each of these faults is caught within one cycle of becoming visible.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int BANK_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_IEN  = 3'd1,
    A_IDFC = 3'd2,
    A_LCTL = 3'd3,
    A_MCTL = 3'd4,
    A_LSTS = 3'd5,
    A_MSTS = 3'd6,
    A_SCR  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic thr;
    logic ien;
    logic fctl;
    logic lctl;
    logic mctl;
    logic scr;
    logic div_lo;
    logic div_hi;
  } wr_sel_t;

  function automatic logic [DATA_W-1:0] word_mask(input logic [1:0] wl);
    case (wl)
      2'b00:   return 8'h1f;
      2'b01:   return 8'h3f;
      2'b10:   return 8'h7f;
      default: return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
  import uart_regs_pkg::*;
(
  input  logic              cs_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  output wr_sel_t           wr_sel_o,
  output logic              rd_en_o,
  output logic              rx_rd_o
);
  logic wr_act;
  reg_addr_e a;

  assign a       = reg_addr_e'(addr_i);
  assign wr_act  = !cs_ni && wr_i;
  assign rd_en_o = !cs_ni && rd_i;
  assign rx_rd_o = rd_en_o && (a == A_DATA) && !bank_i;

  always_comb begin
    wr_sel_o = '0;
    if (wr_act) begin
      unique case (a)
        A_DATA: if (bank_i) wr_sel_o.div_lo = 1'b1; else wr_sel_o.thr = 1'b1;
        A_IEN:  if (bank_i) wr_sel_o.div_hi = 1'b1; else wr_sel_o.ien = 1'b1;
        A_IDFC: wr_sel_o.fctl = 1'b1;
        A_LCTL: wr_sel_o.lctl = 1'b1;
        A_MCTL: wr_sel_o.mctl = 1'b1;
        A_SCR:  wr_sel_o.scr  = 1'b1;
        default: ;  // status addresses are read-only
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_regs_pkg::*;
#(
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_sel_t           wr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] line_ctl_o,
  output logic [MCTL_W-1:0] modem_ctl_o,
  output logic [IEN_W-1:0]  int_en_o,
  output logic [DATA_W-1:0] fifo_ctl_o,
  output logic [DATA_W-1:0] scratch_o,
  output logic [DATA_W-1:0] div_lo_o,
  output logic [DATA_W-1:0] div_hi_o
);
  localparam int NFULL = 5;

  // byte-wide registers share one template
  logic [NFULL-1:0]             full_en;
  logic [NFULL-1:0][DATA_W-1:0] full_q;

  assign full_en = {wr_sel_i.lctl, wr_sel_i.fctl, wr_sel_i.scr,
                    wr_sel_i.div_lo, wr_sel_i.div_hi};

  for (genvar g = 0; g < NFULL; g++) begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         full_q[g] <= '0;
      else if (full_en[g]) full_q[g] <= wdata_i;
    end
  end

  assign line_ctl_o = full_q[4];
  assign fifo_ctl_o = full_q[3];
  assign scratch_o  = full_q[2];
  assign div_lo_o   = full_q[1];
  assign div_hi_o   = full_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      modem_ctl_o <= '0;
      int_en_o    <= '0;
    end else begin
      if (wr_sel_i.mctl) modem_ctl_o <= wdata_i[MCTL_W-1:0];
      if (wr_sel_i.ien)  int_en_o    <= wdata_i[IEN_W-1:0];
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        word_len_i,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      tx_push_o <= thr_wr_i;
      if (thr_wr_i) tx_data_o <= wdata_i & word_mask(word_len_i);
    end
  end
endmodule

// File: rtl/uart_rd_path.sv
module uart_rd_path
  import uart_regs_pkg::*;
#(
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rx_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  input  logic [DATA_W-1:0] line_ctl_i,
  input  logic [MCTL_W-1:0] modem_ctl_i,
  input  logic [IEN_W-1:0]  int_en_i,
  input  logic [DATA_W-1:0] fifo_ctl_i,
  input  logic [DATA_W-1:0] scratch_i,
  input  logic [DATA_W-1:0] div_lo_i,
  input  logic [DATA_W-1:0] div_hi_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [3:0]        int_id_i,
  input  logic [DATA_W-1:0] line_sts_i,
  input  logic [DATA_W-1:0] modem_sts_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rx_pop_o
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] id_word;

  assign id_word = {fifo_ctl_i[0], fifo_ctl_i[0], 2'b00, int_id_i};

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_DATA:  rd_mux = bank_i ? div_lo_i : (rx_data_i & word_mask(line_ctl_i[1:0]));
      A_IEN:   rd_mux = bank_i ? div_hi_i : DATA_W'(int_en_i);
      A_IDFC:  rd_mux = id_word;
      A_LCTL:  rd_mux = line_ctl_i;
      A_MCTL:  rd_mux = DATA_W'(modem_ctl_i);
      A_LSTS:  rd_mux = line_sts_i;
      A_MSTS:  rd_mux = modem_sts_i;
      default: rd_mux = scratch_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rx_pop_o <= 1'b0;
    end else begin
      rx_pop_o <= rx_rd_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_data_i,
  input  logic [3:0]        int_id_i,
  input  logic [7:0]        line_sts_i,
  input  logic [7:0]        modem_sts_i,
  output logic [15:0]       divisor_o,
  output logic [7:0]        line_ctl_o,
  output logic [MCTL_W-1:0] modem_ctl_o,
  output logic [IEN_W-1:0]  int_en_o,
  output logic [7:0]        fifo_ctl_o
);
  wr_sel_t           wr_sel;
  logic              rd_en, rx_rd, bank;
  logic [DATA_W-1:0] scratch, div_lo, div_hi;

  assign bank      = line_ctl_o[BANK_BIT];
  assign divisor_o = {div_hi, div_lo};

  uart_addr_dec i_dec (
    .cs_ni    (cs_ni),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .bank_i   (bank),
    .wr_sel_o (wr_sel),
    .rd_en_o  (rd_en),
    .rx_rd_o  (rx_rd)
  );

  uart_reg_bank #(.IEN_W(IEN_W), .MCTL_W(MCTL_W)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_sel_i    (wr_sel),
    .wdata_i     (wdata_i),
    .line_ctl_o  (line_ctl_o),
    .modem_ctl_o (modem_ctl_o),
    .int_en_o    (int_en_o),
    .fifo_ctl_o  (fifo_ctl_o),
    .scratch_o   (scratch),
    .div_lo_o    (div_lo),
    .div_hi_o    (div_hi)
  );

  uart_tx_path i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thr_wr_i   (wr_sel.thr),
    .wdata_i    (wdata_i),
    .word_len_i (line_ctl_o[1:0]),
    .tx_push_o  (tx_push_o),
    .tx_data_o  (tx_data_o)
  );

  uart_rd_path #(.IEN_W(IEN_W), .MCTL_W(MCTL_W)) i_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .rx_rd_i     (rx_rd),
    .addr_i      (addr_i),
    .bank_i      (bank),
    .line_ctl_i  (line_ctl_o),
    .modem_ctl_i (modem_ctl_o),
    .int_en_i    (int_en_o),
    .fifo_ctl_i  (fifo_ctl_o),
    .scratch_i   (scratch),
    .div_lo_i    (div_lo),
    .div_hi_i    (div_hi),
    .rx_data_i   (rx_data_i),
    .int_id_i    (int_id_i),
    .line_sts_i  (line_sts_i),
    .modem_sts_i (modem_sts_i),
    .rdata_o     (rdata_o),
    .rx_pop_o    (rx_pop_o)
  );
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [2:0]        addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              tx_push_o,
  input logic [7:0]        tx_data_o,
  input logic              rx_pop_o,
  input logic [7:0]        rx_data_i,
  input logic [3:0]        int_id_i,
  input logic [7:0]        line_sts_i,
  input logic [7:0]        modem_sts_i,
  input logic [15:0]       divisor_o,
  input logic [7:0]        line_ctl_o,
  input logic [MCTL_W-1:0] modem_ctl_o,
  input logic [IEN_W-1:0]  int_en_o,
  input logic [7:0]        fifo_ctl_o
);
  assert_no_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(line_ctl_o) && $stable(divisor_o) && $stable(modem_ctl_o)
              && $stable(int_en_o) && $stable(fifo_ctl_o) && $stable(rdata_o)
              && !tx_push_o && !rx_pop_o);

  assert_push_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(!cs_ni && wr_i && addr_i == 3'd0 && !line_ctl_o[7]));

  assert_pop_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> $past(!cs_ni && rd_i && addr_i == 3'd0 && !line_ctl_o[7]));

  assert_div_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && wr_i && addr_i == 3'd0 && line_ctl_o[7])
      |=> divisor_o[7:0] == $past(wdata_i) && !tx_push_o);

  assert_status_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && wr_i && !rd_i && (addr_i == 3'd5 || addr_i == 3'd6))
      |=> $stable(line_ctl_o) && $stable(divisor_o) && $stable(modem_ctl_o)
          && $stable(int_en_o) && $stable(fifo_ctl_o) && !tx_push_o);

  assert_line_sts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rd_i && addr_i == 3'd5) |=> rdata_o == $past(line_sts_i));

  assert_tx_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> (9'(tx_data_o) >> (5 + $past(line_ctl_o[1:0]))) == 9'd0);

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs_ni && rd_i) |=> $stable(rdata_o));
endmodule

bind uart_host_regs uart_host_regs_chk #(.IEN_W(IEN_W), .MCTL_W(MCTL_W)) i_chk (.*);

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = 8'ha5, line_sts = 8'h60, modem_sts = 8'hb0;
  logic [3:0] int_id = 4'h1;
  logic [7:0] rdata, tx_data, line_ctl, fifo_ctl;
  logic       tx_push, rx_pop;
  logic [15:0] divisor;
  logic [4:0] modem_ctl;
  logic [3:0] int_en;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regs i_uart_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tx_push_o(tx_push),
    .tx_data_o(tx_data), .rx_pop_o(rx_pop), .rx_data_i(rx_data),
    .int_id_i(int_id), .line_sts_i(line_sts), .modem_sts_i(modem_sts),
    .divisor_o(divisor), .line_ctl_o(line_ctl), .modem_ctl_o(modem_ctl),
    .int_en_o(int_en), .fifo_ctl_o(fifo_ctl)
  );

  // behavioural reference model
  int m_lctl, m_mctl, m_ien, m_fctl, m_scr, m_dlo, m_dhi, m_rdata, m_txd;
  bit m_push, m_pop;

  function automatic int wmask(int lc);
    return (1 << (5 + (lc & 3))) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lctl <= 0; m_mctl <= 0; m_ien <= 0; m_fctl <= 0; m_scr <= 0;
      m_dlo <= 0; m_dhi <= 0; m_rdata <= 0; m_txd <= 0; m_push <= 0; m_pop <= 0;
    end else begin
      bit bk;
      bk = m_lctl[7];
      m_push <= 0;
      m_pop  <= 0;
      if (!cs_n && wr) begin
        case (addr)
          0: if (bk) m_dlo <= wdata; else begin m_push <= 1; m_txd <= wdata & wmask(m_lctl); end
          1: if (bk) m_dhi <= wdata; else m_ien <= wdata & 'hf;
          2: m_fctl <= wdata;
          3: m_lctl <= wdata;
          4: m_mctl <= wdata & 'h1f;
          7: m_scr  <= wdata;
          default: ;
        endcase
      end
      if (!cs_n && rd) begin
        case (addr)
          0: if (bk) m_rdata <= m_dlo; else begin m_rdata <= rx_data & wmask(m_lctl); m_pop <= 1; end
          1: m_rdata <= bk ? m_dhi : m_ien;
          2: m_rdata <= (m_fctl[0] ? 'hc0 : 0) | int_id;
          3: m_rdata <= m_lctl;
          4: m_rdata <= m_mctl;
          5: m_rdata <= line_sts;
          6: m_rdata <= modem_sts;
          default: m_rdata <= m_scr;
        endcase
      end
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("rdata", rdata, m_rdata);
      chk("tx_push", tx_push, m_push);
      if (m_push) chk("tx_data", tx_data, m_txd);
      chk("rx_pop", rx_pop, m_pop);
      chk("divisor", divisor, (m_dhi << 8) | m_dlo);
      chk("line_ctl", line_ctl, m_lctl);
      chk("modem_ctl", modem_ctl, m_mctl);
      chk("int_en", int_en, m_ien);
      chk("fifo_ctl", fifo_ctl, m_fctl);
    end
  end

  task automatic acc(bit n_cs, bit r, bit w, int a, int d);
    @(negedge clk);
    cs_n = n_cs; rd = r; wr = w; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    cs_n = 1'b1; rd = 1'b0; wr = 1'b0;
  endtask
  task automatic wr_reg(int a, int d); acc(1'b0, 1'b0, 1'b1, a, d); endtask
  task automatic rd_reg(int a);        acc(1'b0, 1'b1, 1'b0, a, 0); endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd_reg(a);

    cur_req = "R10";  // word lengths with R3 push and R4 pop
    for (int wl = 0; wl < 4; wl++) begin
      wr_reg(3, wl);
      cur_req = "R3"; wr_reg(0, 8'hff); wr_reg(0, 8'h5a);
      cur_req = "R4"; rx_data = 8'(8'hc3 + wl * 17); rd_reg(0);
      cur_req = "R10";
    end

    cur_req = "R5";
    wr_reg(3, 8'h83);
    wr_reg(0, 8'h34); wr_reg(1, 8'h12);
    rd_reg(0); rd_reg(1);
    wr_reg(0, 8'hff); wr_reg(1, 8'h00);
    rd_reg(0); rd_reg(1);

    cur_req = "R7";
    wr_reg(2, 8'hc1); rd_reg(2);
    int_id = 4'h4; rd_reg(2);
    cur_req = "R8";
    wr_reg(4, 8'hff); rd_reg(4);
    wr_reg(7, 8'h5a); rd_reg(7);
    wr_reg(3, 8'h03);

    cur_req = "R6";
    wr_reg(1, 8'hff); rd_reg(1);
    wr_reg(1, 8'h0a); rd_reg(1);
    cur_req = "R7";
    wr_reg(2, 8'h00); rd_reg(2);
    int_id = 4'h1;
    cur_req = "R8";
    rd_reg(3); wr_reg(4, 8'h0c); rd_reg(4); wr_reg(7, 8'ha5); rd_reg(7);

    cur_req = "R9";
    wr_reg(5, 8'hff); wr_reg(6, 8'hff);
    rd_reg(5); rd_reg(6);
    line_sts = 8'h01; modem_sts = 8'h0f;
    rd_reg(5); rd_reg(6);
    for (int a = 1; a < 8; a++) rd_reg(a);

    cur_req = "R2";
    acc(1'b1, 1'b0, 1'b1, 0, 8'h77);
    acc(1'b1, 1'b0, 1'b1, 3, 8'h80);
    acc(1'b1, 1'b0, 1'b1, 1, 8'h0f);
    acc(1'b1, 1'b1, 1'b0, 0, 0);
    acc(1'b1, 1'b1, 1'b0, 7, 0);
    rd_reg(3); rd_reg(1);

    cur_req = "R11";
    rd_reg(7);
    rx_data = 8'h11;
    repeat (4) @(negedge clk);
    rd_reg(0);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule